// File: doc/BRIEF.md
# Power-State Sequencer with Interface Strap Tracking

This block follows the system state of a power controller through four states: standby, active, a safe state entered on a severe fault, and a recovery state that waits for the fault to be cleared. On every clock it picks the single highest-ranked pending trigger and acts on it. An emergency shutdown request ranks first. A go-to-standby request comes next. A power-up request follows. Edges on three strap pins rank last. When the block enters the safe state it fires a one-cycle kill strobe on every rail enable at once. It also pulses dedicated outputs when it powers up or powers down.

Three strap pins set the host interface while the block is active. The first picks SPI or I2C. The second turns the interface CRC on or off. The third picks one of two 7-bit bus addresses. Each strap passes through a synchronizer and then a deglitch counter, and only then is an edge detected. The four control inputs pass through the synchronizer only. A strap edge in the active state rewrites only its own setting, and the state stays active.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, `state_o` reads 0 (standby) and the interface configuration is I2C (`spi_sel_o`=0) with CRC off (`crc_en_o`=0) and address `ADDR_BASE` (0x28). No strobe is asserted. The state encoding is 0 standby, 1 active, 2 safe, 3 recovery.
- R2: An emergency request in standby or active moves the block to safe. All `NUM_RAILS` bits of `rail_kill_o` go high together for exactly one cycle, in the cycle that safe is entered. This request outranks every other trigger.
- R3: The safe state lasts exactly one cycle and always moves on to recovery.
- R4: Recovery holds until `err_clear_i` is seen, and then returns to standby.
- R5: A power-up request in standby moves the block to active and pulses `power_up_o` for one cycle. If a go-to-standby request arrives in the same cycle, the power-up request is ignored.
- R6: A go-to-standby request in active moves the block to standby and pulses `power_down_o` for one cycle. It is outranked only by the emergency request.
- R7: In active, a rising edge on the filtered `strap_spi_i` sets `spi_sel_o` to 1 and a falling edge clears it. The state stays active.
- R8: In active, a rising edge on the filtered `strap_crc_i` sets `crc_en_o` and a falling edge clears it. If a `strap_spi_i` edge falls in the same cycle, the CRC edge is dropped.
- R9: In active, a rising edge on the filtered `strap_addr_i` sets `bus_addr_o` to `ADDR_ALT` (0x2C) and a falling edge sets it back to `ADDR_BASE` (0x28). These edges rank lowest.
- R10: Strap edges that arrive outside the active state change nothing. They are not held for later.
- R11: After synchronization, a strap level must hold for `DEGLITCH_CYC` consecutive cycles before its filtered value changes. A shorter pulse has no effect at all.
- R12: A control input acts `SYNC_STAGES`+1 clock edges after it is sampled. A strap setting changes `SYNC_STAGES`+`DEGLITCH_CYC`+1 edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emerg_i | input | 1 | Emergency shutdown request |
| to_stby_i | input | 1 | Go-to-standby request |
| pwr_up_i | input | 1 | Power-up request |
| err_clear_i | input | 1 | Fault cleared; releases recovery |
| strap_spi_i | input | 1 | Strap choosing SPI (high) or I2C (low) |
| strap_crc_i | input | 1 | Strap turning the interface CRC on (high) or off (low) |
| strap_addr_i | input | 1 | Strap choosing the alternate bus address |
| state_o | output | 2 | Current state (encoding as in R1) |
| rail_kill_o | output | NUM_RAILS | Disable strobe, one bit per rail |
| power_up_o | output | 1 | One-cycle strobe on standby-to-active |
| power_down_o | output | 1 | One-cycle strobe on active-to-standby |
| spi_sel_o | output | 1 | 1 = SPI selected, 0 = I2C |
| crc_en_o | output | 1 | Interface CRC enabled |
| bus_addr_o | output | 7 | Current 7-bit bus address |

## Verification
The bench builds the block with `DEGLITCH_CYC` = 6 and `SYNC_STAGES` = 2. The default deglitch of 1600 cycles (8 µs at 200 MHz) would make each strap scenario very long. With the short window, the bench can drive a strap pulse two cycles shorter than the window and then a level that holds past it, so both sides of the filter boundary are tested. It can also drive spi and CRC strap edges that reach the sequencer in the same cycle, and toggle straps in standby followed by a return to active. All of this fits in a few hundred cycles, and a behavioural model checks every one of them.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   typedef enum logic [1:0] {
      PS_STANDBY = 2'd0,
      PS_ACTIVE  = 2'd1,
      PS_SAFE    = 2'd2,
      PS_RECOVER = 2'd3
   } pwr_state_e;

   typedef struct packed {
      logic spi_sel;
      logic crc_en;
      logic addr_alt;
   } if_cfg_t;

   localparam int NUM_STRAPS = 3;
   localparam int STRAP_SPI  = 0;
   localparam int STRAP_CRC  = 1;
   localparam int STRAP_ADDR = 2;
   localparam int NUM_CTRL   = 4;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin
      assert (STAGES >= 1) else $error("pwr_sync: STAGES must be at least 1");
      assert (W >= 1) else $error("pwr_sync: W must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] one_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) one_q <= '0;
            else        one_q <= d_i;
         end
         assign q_o = one_q;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/strap_deglitch.sv
module strap_deglitch #(
   parameter int DG_CYC = 1600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = (DG_CYC < 2) ? 1 : $clog2(DG_CYC);
   localparam logic [CW-1:0] CNT_LAST = CW'(DG_CYC - 1);

   initial begin
      assert (DG_CYC >= 1) else $error("strap_deglitch: DG_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          level_q, rise_q, fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (s_i != level_q) begin
            if (cnt_q == CNT_LAST) begin
               level_q <= s_i;
               cnt_q   <= '0;
               rise_q  <= s_i;
               fall_q  <= ~s_i;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign level_o = level_q;
   assign rise_o  = rise_q;
   assign fall_o  = fall_q;

   // R11
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> ($past(s_i) && !$past(level_q)));

   // R11
   fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |-> (!$past(s_i) && $past(level_q)));

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
   import pwr_state_pkg::*;
#(
   parameter int         NUM_RAILS = 9,
   parameter logic [6:0] ADDR_BASE = 7'h28,
   parameter logic [6:0] ADDR_ALT  = 7'h2C
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  emerg,
   input  logic                  to_stby,
   input  logic                  pwr_up,
   input  logic                  err_clear,
   input  logic [NUM_STRAPS-1:0] rise,
   input  logic [NUM_STRAPS-1:0] fall,
   output pwr_state_e            state,
   output logic [NUM_RAILS-1:0]  rail_kill,
   output logic                  power_up,
   output logic                  power_down,
   output if_cfg_t               cfg,
   output logic [6:0]            bus_addr
);

   initial begin
      assert (NUM_RAILS >= 1) else $error("pwr_state_fsm: NUM_RAILS must be at least 1");
      assert (ADDR_BASE != ADDR_ALT) else $error("pwr_state_fsm: addresses must differ");
   end

   pwr_state_e st_q, st_d;
   if_cfg_t    cfg_q, cfg_d;
   logic       kill_q, kill_d, up_q, up_d, down_q, down_d;
   logic [NUM_STRAPS-1:0] edge_any;

   assign edge_any = rise | fall;

   always_comb begin
      st_d   = st_q;
      cfg_d  = cfg_q;
      kill_d = 1'b0;
      up_d   = 1'b0;
      down_d = 1'b0;
      unique case (st_q)
         PS_STANDBY: begin
            if (emerg) begin
               st_d   = PS_SAFE;
               kill_d = 1'b1;
            end else if (pwr_up && !to_stby) begin
               st_d = PS_ACTIVE;
               up_d = 1'b1;
            end
         end
         PS_ACTIVE: begin
            if (emerg) begin
               st_d   = PS_SAFE;
               kill_d = 1'b1;
            end else if (to_stby) begin
               st_d   = PS_STANDBY;
               down_d = 1'b1;
            end else if (edge_any[STRAP_SPI]) begin
               cfg_d.spi_sel = rise[STRAP_SPI];
            end else if (edge_any[STRAP_CRC]) begin
               cfg_d.crc_en = rise[STRAP_CRC];
            end else if (edge_any[STRAP_ADDR]) begin
               cfg_d.addr_alt = rise[STRAP_ADDR];
            end
         end
         PS_SAFE:    st_d = PS_RECOVER;
         PS_RECOVER: if (err_clear) st_d = PS_STANDBY;
         default:    st_d = PS_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_STANDBY;
         cfg_q  <= '0;
         kill_q <= 1'b0;
         up_q   <= 1'b0;
         down_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cfg_q  <= cfg_d;
         kill_q <= kill_d;
         up_q   <= up_d;
         down_q <= down_d;
      end
   end

   assign state      = st_q;
   assign cfg        = cfg_q;
   assign rail_kill  = {NUM_RAILS{kill_q}};
   assign power_up   = up_q;
   assign power_down = down_q;
   assign bus_addr   = cfg_q.addr_alt ? ADDR_ALT : ADDR_BASE;

   // R2
   kill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_q |-> (st_q == PS_SAFE && ($past(st_q) == PS_STANDBY || $past(st_q) == PS_ACTIVE)));

   // R3
   safe_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SAFE) |=> (st_q == PS_RECOVER));

   // R4
   recover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_RECOVER && !err_clear) |=> (st_q == PS_RECOVER));

   // R5
   power_up_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_q |-> (st_q == PS_ACTIVE && $past(st_q) == PS_STANDBY));

   // R6
   power_down_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      down_q |-> (st_q == PS_STANDBY && $past(st_q) == PS_ACTIVE));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({kill_q, up_q, down_q}));

   // R10
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PS_ACTIVE) |=> $stable(cfg_q));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_state_pkg::*;
#(
   parameter int         NUM_RAILS    = 9,
   parameter int         SYNC_STAGES  = 2,
   parameter int         DEGLITCH_CYC = 1600,
   parameter logic [6:0] ADDR_BASE    = 7'h28,
   parameter logic [6:0] ADDR_ALT     = 7'h2C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 emerg_i,
   input  logic                 to_stby_i,
   input  logic                 pwr_up_i,
   input  logic                 err_clear_i,
   input  logic                 strap_spi_i,
   input  logic                 strap_crc_i,
   input  logic                 strap_addr_i,
   output logic [1:0]           state_o,
   output logic [NUM_RAILS-1:0] rail_kill_o,
   output logic                 power_up_o,
   output logic                 power_down_o,
   output logic                 spi_sel_o,
   output logic                 crc_en_o,
   output logic [6:0]           bus_addr_o
);

   localparam int SYNC_W = NUM_CTRL + NUM_STRAPS;

   logic [SYNC_W-1:0]     raw_in, syn_in;
   logic [NUM_STRAPS-1:0] strap_syn, strap_lvl, strap_rise, strap_fall;
   pwr_state_e            st;
   if_cfg_t               cfg;

   assign raw_in = {strap_addr_i, strap_crc_i, strap_spi_i,
                    err_clear_i, pwr_up_i, to_stby_i, emerg_i};

   pwr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_in)
   );

   assign strap_syn = syn_in[SYNC_W-1:NUM_CTRL];

   generate
      for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_strap
         strap_deglitch #(.DG_CYC(DEGLITCH_CYC)) u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_i     (strap_syn[g]),
            .level_o (strap_lvl[g]),
            .rise_o  (strap_rise[g]),
            .fall_o  (strap_fall[g])
         );
      end
   endgenerate

   pwr_state_fsm #(
      .NUM_RAILS (NUM_RAILS),
      .ADDR_BASE (ADDR_BASE),
      .ADDR_ALT  (ADDR_ALT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .emerg      (syn_in[0]),
      .to_stby    (syn_in[1]),
      .pwr_up     (syn_in[2]),
      .err_clear  (syn_in[3]),
      .rise       (strap_rise),
      .fall       (strap_fall),
      .state      (st),
      .rail_kill  (rail_kill_o),
      .power_up   (power_up_o),
      .power_down (power_down_o),
      .cfg        (cfg),
      .bus_addr   (bus_addr_o)
   );

   assign state_o   = st;
   assign spi_sel_o = cfg.spi_sel;
   assign crc_en_o  = cfg.crc_en;

   // R10
   strap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PS_ACTIVE && strap_lvl[STRAP_SPI] != $past(strap_lvl[STRAP_SPI])) |=> $stable(spi_sel_o));

endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;

   localparam int NR   = 9;
   localparam int SYNC = 2;
   localparam int DG   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic emerg = 0, to_stby = 0, pwr_up = 0, err_clr = 0;
   logic s_spi = 0, s_crc = 0, s_addr = 0;

   logic [1:0]    state_o;
   logic [NR-1:0] rail_kill_o;
   logic          power_up_o, power_down_o, spi_sel_o, crc_en_o;
   logic [6:0]    bus_addr_o;

   always #2.5 clk = ~clk;

   pwr_state_ctrl #(.NUM_RAILS(NR), .SYNC_STAGES(SYNC), .DEGLITCH_CYC(DG)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .emerg_i (emerg), .to_stby_i (to_stby), .pwr_up_i (pwr_up), .err_clear_i (err_clr),
      .strap_spi_i (s_spi), .strap_crc_i (s_crc), .strap_addr_i (s_addr),
      .state_o (state_o), .rail_kill_o (rail_kill_o),
      .power_up_o (power_up_o), .power_down_o (power_down_o),
      .spi_sel_o (spi_sel_o), .crc_en_o (crc_en_o), .bus_addr_o (bus_addr_o)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int kill_cnt = 0, up_cnt = 0, down_cnt = 0;
   string cur_req = "R1";

   // behavioural reference model
   logic [6:0] m_pipe [SYNC];
   int  m_st = 0;
   bit  m_spi = 0, m_crc = 0, m_alt = 0, m_kill = 0, m_up = 0, m_down = 0;
   bit  m_lvl [3], m_rise [3], m_fall [3];
   int  m_cnt [3];

   always @(posedge clk) begin
      logic [6:0] cs;
      if (!rst_n) begin
         for (int k = 0; k < SYNC; k++) m_pipe[k] = '0;
         for (int j = 0; j < 3; j++) begin m_lvl[j] = 0; m_rise[j] = 0; m_fall[j] = 0; m_cnt[j] = 0; end
         m_st = 0; m_spi = 0; m_crc = 0; m_alt = 0; m_kill = 0; m_up = 0; m_down = 0;
      end else begin
         cs = m_pipe[SYNC-1];
         m_kill = 0; m_up = 0; m_down = 0;
         case (m_st)
            0: if (cs[0]) begin m_st = 2; m_kill = 1; end
               else if (cs[2] && !cs[1]) begin m_st = 1; m_up = 1; end
            1: if (cs[0]) begin m_st = 2; m_kill = 1; end
               else if (cs[1]) begin m_st = 0; m_down = 1; end
               else if (m_rise[0] || m_fall[0]) m_spi = m_rise[0];
               else if (m_rise[1] || m_fall[1]) m_crc = m_rise[1];
               else if (m_rise[2] || m_fall[2]) m_alt = m_rise[2];
            2: m_st = 3;
            default: if (cs[3]) m_st = 0;
         endcase
         for (int j = 0; j < 3; j++) begin
            bit sv;
            sv = cs[4+j];
            m_rise[j] = 0; m_fall[j] = 0;
            if (sv != m_lvl[j]) begin
               if (m_cnt[j] == DG - 1) begin
                  m_lvl[j] = sv; m_cnt[j] = 0; m_rise[j] = sv; m_fall[j] = !sv;
               end else m_cnt[j]++;
            end else m_cnt[j] = 0;
         end
         for (int k = SYNC - 1; k > 0; k--) m_pipe[k] = m_pipe[k-1];
         m_pipe[0] = {s_addr, s_crc, s_spi, err_clr, pwr_up, to_stby, emerg};
      end
   end

   task automatic check_val(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [6:0] exp_addr;
         exp_addr = m_alt ? 7'h2C : 7'h28;
         check_val(cur_req, "state", state_o, m_st);
         check_val(cur_req, "rail_kill", rail_kill_o, m_kill ? {NR{1'b1}} : '0);
         check_val(cur_req, "power_up", power_up_o, m_up);
         check_val(cur_req, "power_down", power_down_o, m_down);
         check_val(cur_req, "spi_sel", spi_sel_o, m_spi);
         check_val(cur_req, "crc_en", crc_en_o, m_crc);
         check_val(cur_req, "bus_addr", bus_addr_o, exp_addr);
         if (rail_kill_o == {NR{1'b1}}) kill_cnt++;
         if (power_up_o) up_cnt++;
         if (power_down_o) down_cnt++;
      end
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ctrl(ref logic sig);
      sig = 1; tick(1); sig = 0;
   endtask

   localparam int CL = SYNC + 4;
   localparam int SL = SYNC + DG + 4;

   initial begin
      tick(5);
      rst_n = 1;
      tick(1);
      // R1 reset values
      check_val("R1", "state", state_o, 0);
      check_val("R1", "spi_sel", spi_sel_o, 0);
      check_val("R1", "crc_en", crc_en_o, 0);
      check_val("R1", "bus_addr", bus_addr_o, 7'h28);
      check_val("R1", "rail_kill", rail_kill_o, 0);

      // R5: stby request overrides power-up
      cur_req = "R5";
      pwr_up = 1; to_stby = 1; tick(3); pwr_up = 0; to_stby = 0;
      tick(CL);
      check_val("R5", "state", state_o, 0);
      pulse_ctrl(pwr_up);
      tick(CL);
      check_val("R5", "state", state_o, 1);
      check_val("R5", "power_up count", up_cnt, 1);

      // R7 spi strap edges
      cur_req = "R7";
      s_spi = 1; tick(SL);
      check_val("R7", "spi_sel", spi_sel_o, 1);
      check_val("R7", "state", state_o, 1);
      s_spi = 0; tick(SL);
      check_val("R7", "spi_sel", spi_sel_o, 0);

      // R11 short glitch is filtered
      cur_req = "R11";
      s_crc = 1; tick(DG - 2); s_crc = 0; tick(SL + 4);
      check_val("R11", "crc_en", crc_en_o, 0);
      cur_req = "R8";
      s_crc = 1; tick(SL);
      check_val("R8", "crc_en", crc_en_o, 1);

      // R9 address strap
      cur_req = "R9";
      s_addr = 1; tick(SL);
      check_val("R9", "bus_addr", bus_addr_o, 7'h2C);
      s_addr = 0; tick(SL);
      check_val("R9", "bus_addr", bus_addr_o, 7'h28);

      // R8 priority: spi edge and crc edge in the same cycle
      cur_req = "R8";
      s_spi = 1; s_crc = 0; tick(SL);
      check_val("R8", "spi_sel", spi_sel_o, 1);
      check_val("R8", "crc_en kept", crc_en_o, 1);

      // R6 go to standby
      cur_req = "R6";
      pulse_ctrl(to_stby);
      tick(CL);
      check_val("R6", "state", state_o, 0);
      check_val("R6", "power_down count", down_cnt, 1);

      // R10 strap edge in standby ignored and not queued
      cur_req = "R10";
      s_spi = 0; tick(SL);
      check_val("R10", "spi_sel", spi_sel_o, 1);
      pulse_ctrl(pwr_up);
      tick(SL);
      check_val("R10", "state", state_o, 1);
      check_val("R10", "spi_sel after return", spi_sel_o, 1);

      // R2 emergency outranks stby request; R3 safe exits; R4 recovery holds
      cur_req = "R2";
      emerg = 1; to_stby = 1; tick(1); emerg = 0; to_stby = 0;
      tick(CL + 2);
      check_val("R2", "kill count", kill_cnt, 1);
      check_val("R3", "state", state_o, 3);
      cur_req = "R4";
      tick(10);
      check_val("R4", "state hold", state_o, 3);
      pulse_ctrl(err_clr);
      tick(CL);
      check_val("R4", "state", state_o, 0);

      // R2 from standby
      cur_req = "R2";
      pulse_ctrl(emerg);
      tick(CL + 2);
      check_val("R2", "kill count", kill_cnt, 2);
      check_val("R2", "state", state_o, 3);
      cur_req = "R12";
      pulse_ctrl(err_clr);
      tick(CL);
      check_val("R12", "state", state_o, 0);
      check_val("R12", "power_down count", down_cnt, 1);

      summary();
   end

endmodule